// File: doc/BRIEF.md
# Single-Wire Slave Output-Write Command Handler

This block is the command layer of a single-wire bus slave that owns two open-drain output channels. It sits above an existing bit-level slave engine. That engine hands it each received byte with a one-cycle valid strobe. It pulses a marker while the most significant bit of an outgoing byte is on the wire, and it pulses a bus-reset indication when the master resets the line. The handler tells the engine what to send: a transmit-enable flag and the byte to load next. When the flag is low, the byte is all ones, so the slave leaves the line released.

Once the command byte 0x5A is received, the handler runs a loop until the next bus reset. In each pass it takes an output byte followed by its bitwise inverse. If the pair checks out, it loads the output latches. It then transmits the acknowledge byte 0xAA, captures the pin levels while the last bit of that byte goes out, and transmits a status byte. A failed check leaves the latches alone and silences the slave until a bus reset.

Top module: `swpio_write_ctrl`

## Requirements
- R1: After system reset (rst_n low), every latch_o bit is 1 (transistor off), tx_en is 0 and tx_byte is 0xFF.
- R2: In the command phase, the byte 0x5A starts the write loop. Any other command byte silences the slave: tx_en stays 0, and later byte pairs do not change the latches until a bus reset.
- R3: The latches load only when the byte following the output byte is its exact 8-bit complement. Bit 0 drives latch_o[0] (channel A) and bit 1 drives latch_o[1] (channel B). The new values appear on latch_o in the cycle after the complement byte's rx_valid.
- R4: If the second byte is not the exact complement, latch_o keeps its old value. From then until a bus reset, tx_en is 0 and tx_byte is 0xFF.
- R5: In the cycle after a valid pair, tx_en is 1 and tx_byte is 0xAA.
- R6: The pins are sampled on the cycle where tx_msb is high during the acknowledge byte. After that cycle tx_byte holds the status: bit 0 = pin A, bit 1 = latch A, bit 2 = pin B, bit 3 = latch B, and bits 7:4 are the complement of bits 3:0.
- R7: A tx_msb pulse during the status byte drops tx_en and returns the handler to accepting a new output byte and complement, without another command byte.
- R8: bus_rst aborts the command in any phase, including mid-pair or mid-transmission. tx_en is 0 the next cycle, the handler waits for a command byte again, and latch_o is unchanged.
- R9: rx_valid pulses during the acknowledge or status bytes are ignored: tx_byte and latch_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_rst | input | 1 | One-cycle pulse: master issued a bus reset |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte from the bit engine |
| tx_msb | input | 1 | One-cycle pulse: MSB of the current outgoing byte is on the wire |
| pin_i | input | NUM_CH | Sensed pin levels, bit 0 = channel A |
| tx_en | output | 1 | Slave is transmitting (acknowledge or status byte) |
| tx_byte | output | 8 | Byte for the bit engine to send; 0xFF when idle |
| latch_o | output | NUM_CH | Output latches, 0 = pulldown on, bit 0 = channel A |

## Verification
The bench varies the external load on the pins, so the status byte has to report the pin level and the latch state separately. A design that returns only the latches, or swaps the A and B fields, shows the wrong status. The complement check is probed with a pair whose low bits are valid but whose upper bits differ. A design that compares only the channel bits would load the latches here and keep responding instead of going silent. Bus resets are applied mid-pair and mid-acknowledge: a design that cleared the latches on bus reset, or kept transmitting, would be caught there. Several passes without a fresh command check that the loop returns to the data phase and not to command decode.

// File: rtl/swpio_pkg.sv
// Shared constants and the phase type of the output-write command handler.
// Assumes a byte-oriented bit engine below it.
package swpio_pkg;
    typedef enum logic [2:0] {
        PH_CMD  = 3'd0,
        PH_DATA = 3'd1,
        PH_INV  = 3'd2,
        PH_ACK  = 3'd3,
        PH_STAT = 3'd4,
        PH_MUTE = 3'd5
    } swp_phase_e;

    localparam logic [7:0] CMD_OUT_WRITE = 8'h5A;
    localparam logic [7:0] ACK_BYTE      = 8'hAA;
    localparam logic [7:0] IDLE_BYTE     = 8'hFF;
endpackage

// File: rtl/swpio_cmd_fsm.sv
// Phase sequencer: decodes the command, holds the output byte and checks its
// complement, and steps through acknowledge and status. It emits a commit
// strobe for the latches and a sample strobe for the status capture.
// Assumes that rx_valid, tx_msb and bus_rst are single-cycle pulses.
module swpio_cmd_fsm
    import swpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_msb,
    output swp_phase_e phase_q,
    output logic [7:0] data_q,
    output logic       commit,
    output logic       sample
);
    swp_phase_e phase_d;
    logic       pair_ok;

    // Complement test of the second byte against the held output byte.
    assign pair_ok = (rx_byte == ~data_q);
    assign commit  = (phase_q == PH_INV) && rx_valid && pair_ok && !bus_rst;
    assign sample  = (phase_q == PH_ACK) && tx_msb && !bus_rst;

    // Next-phase selection; a bus reset overrides every phase.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_CMD:  if (rx_valid) phase_d = (rx_byte == CMD_OUT_WRITE) ? PH_DATA : PH_MUTE;
            PH_DATA: if (rx_valid) phase_d = PH_INV;
            PH_INV:  if (rx_valid) phase_d = pair_ok ? PH_ACK : PH_MUTE;
            PH_ACK:  if (tx_msb)   phase_d = PH_STAT;
            PH_STAT: if (tx_msb)   phase_d = PH_DATA;
            default: phase_d = phase_q;
        endcase
        if (bus_rst) phase_d = PH_CMD;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_CMD;
        else        phase_q <= phase_d;
    end

    // Hold the first byte of each pair.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       data_q <= IDLE_BYTE;
        else if (phase_q == PH_DATA && rx_valid && !bus_rst) data_q <= rx_byte;
    end
endmodule

// File: rtl/swpio_out_latch.sv
// Output latch bank, one flop per channel. It loads on commit and returns to 1
// (pulldown off) on system reset only. Assumes NUM_CH <= 8.
module swpio_out_latch #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [7:0]        new_byte,
    output logic [NUM_CH-1:0] latch_q
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Per-channel latch: load the matching bit of the accepted byte.
        always_ff @(posedge clk) begin
            if (!rst_n)      latch_q[ch] <= 1'b1;
            else if (commit) latch_q[ch] <= new_byte[ch];
        end
    end
endmodule

// File: rtl/swpio_status_cap.sv
// Status capture: on sample it stores {pin, latch} pairs per channel in the low
// nibble and their complement in the high nibble. Assumes NUM_CH <= 2.
module swpio_status_cap #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [NUM_CH-1:0] pin_lvl,
    input  logic [NUM_CH-1:0] latch_lvl,
    output logic [7:0]        status_q
);
    localparam int NIB = 4;
    logic [NIB-1:0] low;

    // Interleave the pin level and the latch state for each channel.
    always_comb begin
        low = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            low[2*ch]     = pin_lvl[ch];
            low[2*ch + 1] = latch_lvl[ch];
        end
    end

    // Status register with a self-checking upper nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)      status_q <= 8'h0F;
        else if (sample) status_q <= {~low, low};
    end
endmodule

// File: rtl/swpio_write_ctrl.sv
// Top of the output-write command handler. It ties the sequencer, latch bank
// and status capture together and selects the byte offered to the bit engine.
// Assumes that the bit engine loads tx_byte whenever it needs the next byte.
module swpio_write_ctrl
    import swpio_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_msb,
    input  logic [NUM_CH-1:0] pin_i,
    output logic              tx_en,
    output logic [7:0]        tx_byte,
    output logic [NUM_CH-1:0] latch_o
);
    swp_phase_e phase_q;
    logic [7:0] data_q;
    logic [7:0] status_q;
    logic       commit;
    logic       sample;

    swpio_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_msb(tx_msb), .phase_q(phase_q), .data_q(data_q),
        .commit(commit), .sample(sample)
    );

    swpio_out_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk(clk), .rst_n(rst_n), .commit(commit), .new_byte(data_q), .latch_q(latch_o)
    );

    swpio_status_cap #(.NUM_CH(NUM_CH)) u_stat (
        .clk(clk), .rst_n(rst_n), .sample(sample), .pin_lvl(pin_i),
        .latch_lvl(latch_o), .status_q(status_q)
    );

    // Transmit selection: acknowledge, then status, otherwise a released line.
    always_comb begin
        tx_en   = 1'b0;
        tx_byte = IDLE_BYTE;
        if (phase_q == PH_ACK) begin
            tx_en   = 1'b1;
            tx_byte = ACK_BYTE;
        end else if (phase_q == PH_STAT) begin
            tx_en   = 1'b1;
            tx_byte = status_q;
        end
    end
endmodule

// File: rtl/swpio_write_ctrl_chk.sv
// Port-level checker for swpio_write_ctrl, attached with bind.
module swpio_write_ctrl_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rst,
    input logic              rx_valid,
    input logic              tx_en,
    input logic [7:0]        tx_byte,
    input logic [NUM_CH-1:0] latch_o
);
    assert_latch_needs_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_o) |-> $past(rx_valid));

    assert_ack_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_o) |-> (tx_en && tx_byte == 8'hAA));

    assert_quiet_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> tx_byte == 8'hFF);

    assert_status_nibbles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_byte != 8'hAA) |-> tx_byte[7:4] == ~tx_byte[3:0]);

    assert_bus_rst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !tx_en);

    assert_bus_rst_keeps_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> $stable(latch_o));
endmodule

bind swpio_write_ctrl swpio_write_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
    .tx_en(tx_en), .tx_byte(tx_byte), .latch_o(latch_o)
);

// File: tb/swpio_write_ctrl_tb.sv
module swpio_write_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_msb = 1'b0;
    logic [1:0] ext_pull = 2'b00;
    logic [1:0] pin_i;
    logic       tx_en;
    logic [7:0] tx_byte;
    logic [1:0] latch_o;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    // Open-drain pin model: low when the latch turns the pulldown on or an external load pulls it.
    assign pin_i = latch_o & ~ext_pull;

    swpio_write_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_msb(tx_msb), .pin_i(pin_i), .tx_en(tx_en),
        .tx_byte(tx_byte), .latch_o(latch_o)
    );

    // Vector: {data, inverse, ext_pull, pair_ok, expected latch, expected status}
    localparam int NV = 7;
    localparam logic [28:0] VEC [NV] = '{
        {8'hFE, 8'h01, 2'b00, 1'b1, 2'b10, 8'h3C},
        {8'hFD, 8'h02, 2'b00, 1'b1, 2'b01, 8'hC3},
        {8'hFF, 8'h00, 2'b01, 1'b1, 2'b11, 8'h1E},
        {8'hFC, 8'h03, 2'b00, 1'b1, 2'b00, 8'hF0},
        {8'hFF, 8'h01, 2'b00, 1'b0, 2'b00, 8'h00},
        {8'h03, 8'hFC, 2'b10, 1'b1, 2'b11, 8'h4B},
        {8'hFE, 8'h41, 2'b00, 1'b0, 2'b11, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic msb_pulse();
        @(negedge clk); tx_msb = 1'b1;
        @(negedge clk); tx_msb = 1'b0;
    endtask

    task automatic bus_reset();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 latch", {6'd0, latch_o}, 8'h03);
        chk("R1 tx_en", {7'd0, tx_en}, 8'h00);
        chk("R1 tx_byte", tx_byte, 8'hFF);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bus_reset();
            send(8'h5A);
            chk("R2 data phase quiet", {7'd0, tx_en}, 8'h00);
            ext_pull = VEC[i][12:11];
            send(VEC[i][28:21]);
            send(VEC[i][20:13]);
            chk(VEC[i][10] ? "R3 latch load" : "R4 latch kept", {6'd0, latch_o}, {6'd0, VEC[i][9:8]});
            if (VEC[i][10]) begin
                chk("R5 ack", tx_byte, 8'hAA);
                msb_pulse();
                chk("R6 status", tx_byte, VEC[i][7:0]);
                msb_pulse();
                chk("R7 back to data", {7'd0, tx_en}, 8'h00);
            end else begin
                chk("R4 mute tx_en", {7'd0, tx_en}, 8'h00);
                chk("R4 mute byte", tx_byte, 8'hFF);
                send(8'hFE); send(8'h01);
                chk("R4 mute no load", {6'd0, latch_o}, {6'd0, VEC[i][9:8]});
            end
        end
        ext_pull = 2'b00;

        // R7: loop twice without a new command byte
        bus_reset(); send(8'h5A);
        send(8'hFE); send(8'h01); msb_pulse(); msb_pulse();
        send(8'hFD); send(8'h02);
        chk("R7 second pass latch", {6'd0, latch_o}, 8'h01);
        chk("R7 second pass ack", tx_byte, 8'hAA);
        // R9: bytes during acknowledge are ignored
        send(8'hFC); send(8'h03);
        chk("R9 ack kept", tx_byte, 8'hAA);
        chk("R9 latch kept", {6'd0, latch_o}, 8'h01);
        // R8: bus reset during acknowledge
        bus_reset();
        chk("R8 tx dropped", {7'd0, tx_en}, 8'h00);
        chk("R8 latch kept", {6'd0, latch_o}, 8'h01);

        // R2: unknown command mutes
        send(8'h33); send(8'hFE); send(8'h01);
        chk("R2 bad cmd latch", {6'd0, latch_o}, 8'h01);
        chk("R2 bad cmd quiet", {7'd0, tx_en}, 8'h00);

        // R8: bus reset mid-pair, then pair without command
        bus_reset(); send(8'h5A); send(8'hFC); bus_reset();
        send(8'h03);
        chk("R8 mid-pair abort", {6'd0, latch_o}, 8'h01);
        chk("R8 waits for command", {7'd0, tx_en}, 8'h00);

        // R1: system reset restores latches
        bus_reset(); send(8'h5A); send(8'hFC); send(8'h03);
        chk("R3 both on", {6'd0, latch_o}, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 sys reset latch", {6'd0, latch_o}, 8'h03);
        chk("R1 sys reset tx", tx_byte, 8'hFF);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule